// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A 32-pin general-purpose I/O block behind a simple register port. Software picks, per pin, whether the pin drives the pad or listens to it, sets the levels driven on output pins, and reads back a data word. In that word, input pins show their synchronised pad level and output pins show the value last written.

Every pad input passes through a two-flop synchroniser. Each pin is then watched for edges, in one of two senses: falling edges only, or any change of level. A detected edge sets a sticky per-pin flag. Software clears a flag by writing a one to it. A per-pin enable gates the flags onto a single interrupt line to the host.

In every register, pin n occupies bit (31 − n), so pin 0 is the most significant bit. The pad vectors are indexed by pin number.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After synchronous reset, every register reads as zero, all pads are inputs (`pad_oe` all zero), `pad_out` is zero and `irq` is low.
- R2: A direction bit of 1 makes a pin an output. `pad_oe[n]` equals bit (31 − n) of the direction register.
- R3: `pad_out[n]` equals bit (31 − n) of the data register, whatever the direction.
- R4: A read of the data register returns, in bit (31 − n), the written data bit when pin n is an output, and the synchronised level of `pad_in[n]` when pin n is an input.
- R5: With control bit (31 − n) at 0, both a rising and a falling level change on pin n set event flag (31 − n).
- R6: With control bit (31 − n) at 1, a falling change on pin n sets event flag (31 − n) and a rising change leaves it clear.
- R7: Writing the event register clears each flag whose written bit is 1 and leaves every flag whose written bit is 0 unchanged. A write never sets a flag.
- R8: When an edge on a pin is detected in the same cycle as a write that clears that pin's flag, the flag stays set.
- R9: `irq` is high exactly while some bit is set in both the event register and the mask register.
- R10: Register offsets: 0x00 direction, 0x04 open-drain select (stored and read back, with no effect on the pads), 0x08 data, 0x0C event, 0x10 mask, 0x14 control. A write is taken on any clock edge where `bus_we` is high. `bus_rdata` holds the register addressed in the previous cycle. Any other offset reads as zero and ignores writes.
- R11: A pad change that lands between clock edges sets its event flag, and so can raise `irq`, on the third rising edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous cycle's address |
| pad_in | input | 32 | Pad input levels, index = pin number |
| pad_out | output | 32 | Pad output levels, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| irq | output | 1 | Combined interrupt, high while an enabled flag is set |

## Verification
The assertions assume that the pad inputs are held low while reset is applied. Without that, the synchroniser stages would leave reset at zero and then report a spurious rising edge. They also assume that bus offsets are either one of the six mapped ones or are meant to read as zero. The bench changes pads and bus signals only on falling clock edges, keeps `pad_in` at zero through reset, and starts every edge check from a cleared event register. That way each flag observed can be traced to the single pin toggled in that step.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int PIN_COUNT = 32;
    localparam int OFF_W     = 5;

    typedef enum logic [OFF_W-1:0] {
        OFF_DIR = 5'h00,
        OFF_ODS = 5'h04,
        OFF_DAT = 5'h08,
        OFF_EVT = 5'h0C,
        OFF_MSK = 5'h10,
        OFF_CTL = 5'h14
    } reg_off_e;

    typedef enum logic {
        SENSE_ANY  = 1'b0,
        SENSE_FALL = 1'b1
    } sense_e;

    typedef struct packed {
        logic [PIN_COUNT-1:0] dir;
        logic [PIN_COUNT-1:0] ods;
        logic [PIN_COUNT-1:0] dat;
        logic [PIN_COUNT-1:0] msk;
        logic [PIN_COUNT-1:0] ctl;
    } cfg_regs_t;

    function automatic logic is_mapped(input logic [OFF_W-1:0] off);
        return (off == OFF_DIR) || (off == OFF_ODS) || (off == OFF_DAT) ||
               (off == OFF_EVT) || (off == OFF_MSK) || (off == OFF_CTL);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] prior_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prior_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= pad_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prior_q <= '0;
        else     prior_q <= chain[LAST];
    end

    assign level_o = chain[LAST];
    assign prior_o = prior_q;

    // R11: the previous sample is exactly the synchronised level one cycle ago
    a_r11_prior_lags_level: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> prior_o == $past(level_o));

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_ctrl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] prior_i,
    input  logic [WIDTH-1:0] fall_only_i,
    output logic [WIDTH-1:0] hit_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        sense_e mode;
        logic   changed;
        logic   fell;

        assign mode    = sense_e'(fall_only_i[b]);
        assign changed = level_i[b] ^ prior_i[b];
        assign fell    = prior_i[b] & ~level_i[b];

        always_comb begin
            unique case (mode)
                SENSE_FALL: hit_o[b] = fell;
                default:    hit_o[b] = changed;
            endcase
        end
    end

    // R6: in falling-only sense a hit always leaves the pin low
    a_r6_fall_hit_is_low: assert property (@(posedge clk) disable iff (rst)
        ((hit_o & fall_only_i & level_i) == '0));

endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    logic [WIDTH-1:0] flags_q;
    logic [WIDTH-1:0] flags_d;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R7: a flag only rises when an edge was reported in the cycle before
    a_r7_rise_needs_edge: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0));

    // R7: a flag only drops when a one was written to it
    a_r7_drop_needs_clear: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~flags_o & $past(flags_o) & ~$past(clr_i)) == '0));

    // R8: an edge always leaves its flag set, even under a clear
    a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_i) & ~flags_o) == '0));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int N_PINS   = PIN_COUNT,
    parameter int AW       = OFF_W,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic              irq
);
    localparam int TOP_BIT = N_PINS - 1;

    cfg_regs_t         cfg_q;
    logic [N_PINS-1:0] lvl_pin, prior_pin;
    logic [N_PINS-1:0] lvl_reg, prior_reg;
    logic [N_PINS-1:0] hit_reg;
    logic [N_PINS-1:0] evt_reg;
    logic [N_PINS-1:0] evt_clr;
    logic [N_PINS-1:0] rd_mux;

    // synchroniser in pin order
    gpio_pin_sync #(.WIDTH(N_PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pad_i   (pad_in),
        .level_o (lvl_pin),
        .prior_o (prior_pin)
    );

    // pin n <-> register bit (TOP_BIT - n)
    for (genvar n = 0; n < N_PINS; n++) begin : g_map
        assign lvl_reg[TOP_BIT-n]   = lvl_pin[n];
        assign prior_reg[TOP_BIT-n] = prior_pin[n];
        assign pad_oe[n]            = cfg_q.dir[TOP_BIT-n];
        assign pad_out[n]           = cfg_q.dat[TOP_BIT-n];
    end

    gpio_edge_detect #(.WIDTH(N_PINS)) u_edge (
        .clk         (clk),
        .rst         (rst),
        .level_i     (lvl_reg),
        .prior_i     (prior_reg),
        .fall_only_i (cfg_q.ctl),
        .hit_o       (hit_reg)
    );

    assign evt_clr = (bus_we && bus_addr == OFF_EVT) ? bus_wdata : '0;

    gpio_event_bank #(.WIDTH(N_PINS)) u_events (
        .clk     (clk),
        .rst     (rst),
        .set_i   (hit_reg),
        .clr_i   (evt_clr),
        .flags_o (evt_reg)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFF_DIR: cfg_q.dir <= bus_wdata;
                OFF_ODS: cfg_q.ods <= bus_wdata;
                OFF_DAT: cfg_q.dat <= bus_wdata;
                OFF_MSK: cfg_q.msk <= bus_wdata;
                OFF_CTL: cfg_q.ctl <= bus_wdata;
                default: ;
            endcase
        end
    end

    // read path, registered
    always_comb begin
        unique case (bus_addr)
            OFF_DIR: rd_mux = cfg_q.dir;
            OFF_ODS: rd_mux = cfg_q.ods;
            OFF_DAT: rd_mux = (cfg_q.dir & cfg_q.dat) | (~cfg_q.dir & lvl_reg);
            OFF_EVT: rd_mux = evt_reg;
            OFF_MSK: rd_mux = cfg_q.msk;
            OFF_CTL: rd_mux = cfg_q.ctl;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_mux;
    end

    assign irq = |(evt_reg & cfg_q.msk);

    // R1: one cycle after reset the pads are inputs and the interrupt is quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && !irq));

    // R2: a direction write reaches pin 0 enable from the top data bit
    a_r2_dir_write_pin0: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && bus_addr == OFF_DIR) |-> pad_oe[0] == $past(bus_wdata[TOP_BIT]));

    // R10: offsets outside the map read as zero in the following cycle
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        !is_mapped(bus_addr) |=> bus_rdata == '0);

    // R9: interrupt low whenever no source is enabled
    a_r9_no_mask_no_irq: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.msk == '0) |-> !irq);

endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;

    localparam int NP = 32;
    localparam logic [4:0] A_DIR = 5'h00, A_ODS = 5'h04, A_DAT = 5'h08,
                           A_EVT = 5'h0C, A_MSK = 5'h10, A_CTL = 5'h14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_ctrl uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [NP-1:0] flip(input logic [NP-1:0] v);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) r[NP-1-i] = v[i];
        return r;
    endfunction

    function automatic logic [NP-1:0] pbit(input int pin);
        return 32'h8000_0000 >> pin;
    endfunction

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [NP-1:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] v, exp;
        tick(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        foreach (exp[i]) exp[i] = 1'b0;
        for (int k = 0; k < 6; k++) begin
            rd(5'(k * 4), v);
            check("R1 reg", v, '0);
        end
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 irq", {31'b0, irq}, '0);

        // R10 read-back of every writable register, unmapped offsets
        wr(A_ODS, 32'h5A5A_0FF0); rd(A_ODS, v); check("R10 ods", v, 32'h5A5A_0FF0);
        check("R10 ods no pad_oe", pad_oe, '0);
        check("R10 ods no pad_out", pad_out, '0);
        wr(A_MSK, 32'h0123_4567); rd(A_MSK, v); check("R10 msk", v, 32'h0123_4567);
        wr(A_CTL, 32'h89AB_CDEF); rd(A_CTL, v); check("R10 ctl", v, 32'h89AB_CDEF);
        wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, v); check("R10 unmapped", v, '0);
        rd(5'h1C, v); check("R10 unmapped 1C", v, '0);
        rd(5'h02, v); check("R10 unaligned", v, '0);
        wr(A_MSK, '0); wr(A_CTL, '0);

        // R2 / R3 pin order mapping, several patterns
        foreach (exp[i]) exp[i] = 1'b0;
        for (int p = 0; p < 4; p++) begin
            logic [NP-1:0] pat;
            pat = 32'hA500_0F3C ^ (32'h1357_9BDF << p);
            wr(A_DIR, pat);
            check("R2 pad_oe", pad_oe, flip(pat));
            rd(A_DIR, v); check("R2 readback", v, pat);
            wr(A_DAT, ~pat);
            check("R3 pad_out", pad_out, flip(~pat));
        end

        // R4 data read mixes outputs and synchronised inputs
        wr(A_DIR, 32'hFFFF_0000);
        wr(A_DAT, 32'h1234_5678);
        for (int p = 0; p < 3; p++) begin
            pad_in = 32'hCAFE_BABE + 32'(p * 32'h1111_1111);
            tick(3);
            rd(A_DAT, v);
            exp = (32'hFFFF_0000 & 32'h1234_5678) | (32'h0000_FFFF & flip(pad_in));
            check("R4 data read", v, exp);
        end
        wr(A_DIR, '0);
        pad_in = '0;
        tick(4);
        wr(A_EVT, '1);
        rd(A_EVT, v); check("R7 clear all", v, '0);

        // R5 both-edge sweep, R6 falling-only sweep, every pin
        for (int m = 0; m < 2; m++) begin
            wr(A_CTL, m == 1 ? '1 : '0);
            for (int n = 0; n < NP; n++) begin
                pad_in[n] = 1'b1;
                tick(4);
                rd(A_EVT, v);
                if (m == 0) check("R5 rise", v, pbit(n));
                else        check("R6 rise ignored", v, '0);
                wr(A_EVT, '1);
                pad_in[n] = 1'b0;
                tick(4);
                rd(A_EVT, v);
                check(m == 0 ? "R5 fall" : "R6 fall", v, pbit(n));
                wr(A_EVT, '1);
            end
        end
        wr(A_CTL, '0);

        // R11 latency through synchroniser and flag
        wr(A_MSK, '1);
        @(negedge clk);
        pad_in[5] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 not yet", {31'b0, irq}, '0);
        @(posedge clk); @(negedge clk);
        check("R11 third edge", {31'b0, irq}, 32'd1);
        wr(A_EVT, '1);
        pad_in[5] = 1'b0;
        tick(4);
        wr(A_EVT, '1);
        wr(A_MSK, '0);

        // R8 edge in the same cycle as its clear
        pad_in[7] = 1'b1;
        tick(4);
        @(negedge clk);
        pad_in[7] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_we = 1'b1; bus_addr = A_EVT; bus_wdata = pbit(7);
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
        rd(A_EVT, v); check("R8 edge wins", v, pbit(7));
        wr(A_EVT, pbit(7));
        rd(A_EVT, v); check("R7 plain clear", v, '0);

        // R7 partial clear and zero write
        pad_in[0] = 1'b1; pad_in[1] = 1'b1; pad_in[2] = 1'b1;
        tick(4);
        wr(A_EVT, '0);
        rd(A_EVT, v); check("R7 zero write", v, pbit(0) | pbit(1) | pbit(2));
        wr(A_EVT, pbit(1));
        rd(A_EVT, v); check("R7 partial", v, pbit(0) | pbit(2));

        // R9 interrupt gating
        check("R9 mask zero", {31'b0, irq}, '0);
        wr(A_MSK, pbit(1));
        check("R9 masked flag clear", {31'b0, irq}, '0);
        wr(A_MSK, pbit(2));
        check("R9 enabled flag", {31'b0, irq}, 32'd1);
        wr(A_EVT, pbit(0));
        check("R9 other cleared", {31'b0, irq}, 32'd1);
        wr(A_EVT, pbit(2));
        check("R9 flag cleared", {31'b0, irq}, '0);

        // R1 reset again clears everything
        wr(A_DIR, '1);
        pad_in = '0;
        tick(4);
        rst = 1'b1; tick(2); rst = 1'b0;
        check("R1 re-reset pad_oe", pad_oe, '0);
        rd(A_MSK, v); check("R1 re-reset msk", v, '0);
        rd(A_EVT, v); check("R1 re-reset evt", v, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule